// File: doc/BRIEF.md
# Accumulator Machine Timing and Control Sequencer

This block is the hardwired control unit of a small 16-bit computer with one accumulator and 12-bit addresses. A step counter walks through timing states T0 to T6, and each state enables a fixed set of register transfers. The unit carries its own datapath: a program counter, an address register, an instruction register, a data register, the accumulator with its extend bit E, and the indirect flag. It fetches each instruction through a read-only memory port and carries it out to completion. That lets a bench run small programs and watch the results at the ports.

An instruction word uses these fields. Bit 15 is the indirect flag. Bits 14 to 12 hold the opcode. Bits 11 to 0 hold either an address or a set of operation-select bits. Opcodes 0 to 6 are memory-reference instructions. Opcode 7 with the indirect flag clear is a register-reference instruction. Opcode 7 with the indirect flag set is an input instruction. The memory port is combinational: the word at `mem_addr` must appear on `mem_rdata` in the same cycle. The byte input is a valid/ready stream. `in_ready` is high only while an input instruction waits at T3. The sequencer stays at T3 until `in_valid` is high, and one byte is taken in the cycle where both signals are high. The producer may hold `in_valid` high at any time; nothing is consumed outside that window.

Top module: `acc_ctrl_seq`

## Requirements
- R1: After reset, `t_step` is 0000001 (T0), `pc` is 0, `ac` is 0, `e_flag` is 0, `halted` is 0 and `in_ready` is 0.
- R2: `t_step` is one-hot and advances one step per clock. At T0, AR takes PC, so `mem_addr` shows the old PC during T1. At T1, IR takes the memory word at AR and PC increments by one.
- R3: From T2 to the end of the instruction, `d_op` is the one-hot decode of IR[14:12]. At T2, AR takes IR[11:0] and the indirect flag takes IR[15].
- R4: At T3, for opcodes 0 to 6 with the indirect flag set, AR takes bits 11:0 of the memory word at AR. With the flag clear, AR keeps the address from the instruction.
- R5: For opcodes 0 to 6, DR loads from memory at T4. At T5, opcode 0 sets AC to AC AND DR and leaves E unchanged. Opcode 1 sets AC to AC + DR and puts the carry-out in E. Opcode 2 sets AC to DR. Opcodes 3 to 6 change neither AC nor E. The step after T5 is T0, so each such instruction takes 6 cycles.
- R6: A register-reference instruction (opcode 7, indirect clear) acts at T3 and then returns to T0, so it takes 4 cycles. Its select bits are: bit 11 clears AC; bit 9 complements AC; bit 7 rotates AC right through E (AC[15] takes E and E takes AC[0]); bit 6 rotates AC left through E (AC[0] takes E and E takes AC[15]); bit 5 adds one to AC and leaves E unchanged.
- R7: When several select bits are set, they act in this fixed order within one instruction: clear, complement, rotate right, rotate left, increment.
- R8: Register-reference bit 0 halts the unit. `halted` goes high after that T3 step and `t_step` reads all zeros. PC, AC and E then stay unchanged until reset. Other select bits in the same word still take effect.
- R9: For an input instruction (opcode 7, indirect set, bit 11 set), `in_ready` is high at T3. The unit stays at T3 while `in_valid` is low. In the handshake cycle, AC[7:0] takes `in_data`, AC[15:8] is kept, and the next step is T0. An input-class word with bit 11 clear does nothing and returns to T0 after T3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory read address (the AR register) |
| mem_rdata | input | 16 | Memory word at `mem_addr`, same cycle |
| in_data | input | 8 | Input stream byte |
| in_valid | input | 1 | Input stream byte valid |
| in_ready | output | 1 | Sequencer waiting at T3 of an input instruction |
| t_step | output | 7 | One-hot timing state T0..T6, zero when halted |
| d_op | output | 8 | One-hot opcode decode |
| pc | output | 12 | Program counter |
| ac | output | 16 | Accumulator |
| e_flag | output | 1 | Extend/carry bit |
| halted | output | 1 | Halt latched |

## Verification
A stuck or skipped timing step shows up on `t_step` within a cycle. The same fault also shifts the instruction length, so the next instruction lands on the wrong memory word within one instruction. A wrong AR value at T2 or T3 appears on `mem_addr` in the following cycle, and it loads a wrong DR, which reaches `ac` at the end of that same instruction. Errors in the order of the select bits, in the carry or in the rotate path show in `ac` and `e_flag` as soon as that register-reference instruction returns to T0.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OPC_W   = 3;
  localparam int NUM_OPS = 1 << OPC_W;

  // register-reference select bit positions
  localparam int SEL_CLR = 11;
  localparam int SEL_CMP = 9;
  localparam int SEL_ROR = 7;
  localparam int SEL_ROL = 6;
  localparam int SEL_INC = 5;
  localparam int SEL_HLT = 0;
  localparam int SEL_INP = 11;

  typedef struct packed {
    logic ar_from_pc;
    logic ir_load;
    logic pc_inc;
    logic ar_from_ir;
    logic ar_from_mem;
    logic dr_load;
  } xfer_t;

  typedef struct packed {
    logic do_and;
    logic do_add;
    logic do_lda;
    logic do_rr;
    logic do_inp;
  } alu_cmd_t;

  typedef struct packed {
    logic clr;
    logic cmp;
    logic ror;
    logic rol;
    logic inc;
  } rr_sel_t;

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int STEPS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             stall,
  input  logic             halt_set,
  output logic [STEPS-1:0] t_step,
  output logic             halted
);
  localparam int SC_W = $clog2(STEPS);

  logic [SC_W-1:0] sc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc     <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (halt_set) begin
        halted <= 1'b1;
        sc     <= '0;
      end else if (stall) begin
        sc <= sc;
      end else if (clear || sc == SC_W'(STEPS - 1)) begin
        sc <= '0;
      end else begin
        sc <= sc + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign t_step[i] = !halted && (sc == SC_W'(i));
  end

  // R2
  step_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> $countones(t_step) == 1);

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && t_step == '0);

endmodule

// File: rtl/op_decoder.sv
module op_decoder
  import acc_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPC_W-1:0]   opc,
  input  logic               ind,
  input  logic               sel_b11,
  input  logic               sel_b0,
  input  logic [5:0]         t,
  input  logic               in_valid,
  output logic [NUM_OPS-1:0] d_op,
  output xfer_t              xfer,
  output alu_cmd_t           cmd,
  output logic               sc_clear,
  output logic               sc_stall,
  output logic               halt_set,
  output logic               in_ready
);
  for (genvar k = 0; k < NUM_OPS; k++) begin : g_dec
    assign d_op[k] = (opc == OPC_W'(k));
  end

  logic d7, rr_step, io_step;

  always_comb begin
    d7      = d_op[NUM_OPS-1];
    rr_step = t[3] && d7 && !ind;
    io_step = t[3] && d7 && ind;

    xfer.ar_from_pc  = t[0];
    xfer.ir_load     = t[1];
    xfer.pc_inc      = t[1];
    xfer.ar_from_ir  = t[2];
    xfer.ar_from_mem = t[3] && !d7 && ind;
    xfer.dr_load     = t[4];

    in_ready   = io_step && sel_b11;
    sc_stall   = in_ready && !in_valid;

    cmd.do_and = t[5] && d_op[0];
    cmd.do_add = t[5] && d_op[1];
    cmd.do_lda = t[5] && d_op[2];
    cmd.do_rr  = rr_step;
    cmd.do_inp = in_ready && in_valid;

    halt_set   = rr_step && sel_b0;
    sc_clear   = t[5] || rr_step || (io_step && !sc_stall);
  end

  // R9
  inp_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  // R6
  rr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.do_rr |=> !cmd.do_rr);

endmodule

// File: rtl/acc_exec.sv
module acc_exec
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  alu_cmd_t          cmd,
  input  rr_sel_t           sel,
  input  logic [DATA_W-1:0] dr,
  input  logic [IN_W-1:0]   in_data,
  output logic [DATA_W-1:0] ac,
  output logic              e_flag
);
  logic [DATA_W-1:0] ac_nx, rr_a;
  logic              e_nx, rr_c, spill;

  always_comb begin
    rr_a  = ac;
    rr_c  = e_flag;
    spill = 1'b0;
    if (sel.clr) rr_a = '0;
    if (sel.cmp) rr_a = ~rr_a;
    if (sel.ror) begin
      spill = rr_a[0];
      rr_a  = {rr_c, rr_a[DATA_W-1:1]};
      rr_c  = spill;
    end
    if (sel.rol) begin
      spill = rr_a[DATA_W-1];
      rr_a  = {rr_a[DATA_W-2:0], rr_c};
      rr_c  = spill;
    end
    if (sel.inc) rr_a = rr_a + 1'b1;

    ac_nx = ac;
    e_nx  = e_flag;
    if (cmd.do_and)      ac_nx = ac & dr;
    else if (cmd.do_add) {e_nx, ac_nx} = {1'b0, ac} + {1'b0, dr};
    else if (cmd.do_lda) ac_nx = dr;
    else if (cmd.do_rr) begin
      ac_nx = rr_a;
      e_nx  = rr_c;
    end else if (cmd.do_inp) ac_nx = {ac[DATA_W-1:IN_W], in_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac     <= '0;
      e_flag <= 1'b0;
    end else begin
      ac     <= ac_nx;
      e_flag <= e_nx;
    end
  end

  // R5
  and_keeps_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.do_and |=> e_flag == $past(e_flag));

  // R9
  inp_upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.do_inp |=> ac[DATA_W-1:IN_W] == $past(ac[DATA_W-1:IN_W]));

  // R5
  idle_ac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == '0) |=> $stable(ac) && $stable(e_flag));

endmodule

// File: rtl/acc_ctrl_seq.sv
module acc_ctrl_seq
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IN_W   = 8,
  parameter int STEPS  = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic [ADDR_W+OPC_W:0]   mem_rdata,
  input  logic [IN_W-1:0]         in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic [STEPS-1:0]        t_step,
  output logic [NUM_OPS-1:0]      d_op,
  output logic [ADDR_W-1:0]       pc,
  output logic [ADDR_W+OPC_W:0]   ac,
  output logic                    e_flag,
  output logic                    halted
);
  localparam int DATA_W = ADDR_W + OPC_W + 1;
  localparam int IND_B  = DATA_W - 1;

  logic [ADDR_W-1:0] ar;
  logic [DATA_W-1:0] ir, dr;
  logic              ind;
  xfer_t             xfer;
  alu_cmd_t          cmd;
  rr_sel_t           sel;
  logic              sc_clear, sc_stall, halt_set;

  assign mem_addr = ar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      ar  <= '0;
      ir  <= '0;
      dr  <= '0;
      ind <= 1'b0;
    end else begin
      if (xfer.ar_from_pc)       ar <= pc;
      else if (xfer.ar_from_ir)  ar <= ir[ADDR_W-1:0];
      else if (xfer.ar_from_mem) ar <= mem_rdata[ADDR_W-1:0];
      if (xfer.ir_load) ir <= mem_rdata;
      if (xfer.pc_inc)  pc <= pc + 1'b1;
      if (xfer.ar_from_ir) ind <= ir[IND_B];
      if (xfer.dr_load) dr <= mem_rdata;
    end
  end

  assign sel = '{clr: ir[SEL_CLR], cmp: ir[SEL_CMP], ror: ir[SEL_ROR],
                 rol: ir[SEL_ROL], inc: ir[SEL_INC]};

  seq_counter #(.STEPS(STEPS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (sc_clear),
    .stall    (sc_stall),
    .halt_set (halt_set),
    .t_step   (t_step),
    .halted   (halted)
  );

  op_decoder u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .opc      (ir[IND_B-1:ADDR_W]),
    .ind      (ind),
    .sel_b11  (ir[SEL_INP]),
    .sel_b0   (ir[SEL_HLT]),
    .t        (t_step[5:0]),
    .in_valid (in_valid),
    .d_op     (d_op),
    .xfer     (xfer),
    .cmd      (cmd),
    .sc_clear (sc_clear),
    .sc_stall (sc_stall),
    .halt_set (halt_set),
    .in_ready (in_ready)
  );

  acc_exec #(.DATA_W(DATA_W), .IN_W(IN_W)) u_exec (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .sel     (sel),
    .dr      (dr),
    .in_data (in_data),
    .ac      (ac),
    .e_flag  (e_flag)
  );

  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_step[0] |=> mem_addr == $past(pc));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !t_step[1] |=> $stable(pc));

  // R5
  wrap_after_t5_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_step[5] |=> t_step[0]);

  // R3
  ind_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_step[2] |=> ind == $past(ir[IND_B]));

endmodule

// File: tb/acc_ctrl_seq_tb.sv
`timescale 1ns/1ps
module acc_ctrl_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [6:0]  t_step;
  logic [7:0]  d_op;
  logic [11:0] pc;
  logic [15:0] ac;
  logic        e_flag, halted;

  logic [15:0] mem [0:255];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;
  assign mem_rdata = mem[mem_addr[7:0]];

  acc_ctrl_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .t_step(t_step), .d_op(d_op), .pc(pc), .ac(ac), .e_flag(e_flag),
    .halted(halted)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic test_reset();
    clear_mem();
    do_reset();
    check("R1 t_step", t_step, 7'b0000001);
    check("R1 pc", pc, 0);
    check("R1 ac", ac, 0);
    check("R1 e", e_flag, 0);
    check("R1 halted", halted, 0);
    check("R1 in_ready", in_ready, 0);
  endtask

  task automatic test_fetch();
    clear_mem();
    mem[0] = 16'h2010; mem[8'h10] = 16'h1234;
    do_reset();
    tick(1);
    check("R2 T1 step", t_step, 7'b0000010);
    check("R2 T1 addr", mem_addr, 12'h000);
    tick(1);
    check("R2 T2 step", t_step, 7'b0000100);
    check("R2 pc inc", pc, 1);
    tick(1);
    check("R3 T3 step", t_step, 7'b0001000);
    check("R3 decode", d_op, 8'b0000_0100);
    check("R3 ar from ir", mem_addr, 12'h010);
    tick(3);
    check("R5 lda", ac, 16'h1234);
    check("R5 back to T0", t_step, 7'b0000001);
  endtask

  task automatic test_memref();
    clear_mem();
    mem[0] = 16'h2010; mem[8'h10] = 16'h1234;
    mem[1] = 16'h1011; mem[8'h11] = 16'hF000;
    mem[2] = 16'h0012; mem[8'h12] = 16'h00FF;
    mem[3] = 16'h4013; mem[8'h13] = 16'hFFFF;
    do_reset();
    tick(6);
    check("R5 lda ac", ac, 16'h1234);
    tick(6);
    check("R5 add ac", ac, 16'h0234);
    check("R5 add carry", e_flag, 1);
    tick(6);
    check("R5 and ac", ac, 16'h0034);
    check("R5 and keeps e", e_flag, 1);
    tick(6);
    check("R5 op4 no effect", ac, 16'h0034);
    check("R5 op4 pc", pc, 4);
    check("R5 op4 T0", t_step, 7'b0000001);
  endtask

  task automatic test_indirect();
    clear_mem();
    mem[0] = 16'hA020; mem[8'h20] = 16'h0030; mem[8'h30] = 16'h5A5A;
    mem[1] = 16'h2020;
    do_reset();
    tick(4);
    check("R4 indirect addr", mem_addr, 12'h030);
    tick(2);
    check("R4 indirect lda", ac, 16'h5A5A);
    tick(4);
    check("R4 direct addr kept", mem_addr, 12'h020);
    tick(2);
    check("R4 direct lda", ac, 16'h0030);
  endtask

  task automatic test_regref();
    clear_mem();
    mem[0] = 16'h2040; mem[8'h40] = 16'h8001;
    mem[1] = 16'h7080; mem[2] = 16'h7040; mem[3] = 16'h7200;
    mem[4] = 16'h7020; mem[5] = 16'h7800;
    do_reset();
    tick(6);
    tick(4);
    check("R6 ror ac", ac, 16'h4000);
    check("R6 ror e", e_flag, 1);
    check("R6 4-cycle T0", t_step, 7'b0000001);
    tick(4);
    check("R6 rol ac", ac, 16'h8001);
    check("R6 rol e", e_flag, 0);
    tick(4);
    check("R6 cmp", ac, 16'h7FFE);
    tick(4);
    check("R6 inc", ac, 16'h7FFF);
    tick(4);
    check("R6 clr", ac, 16'h0000);
    check("R6 pc", pc, 6);
  endtask

  task automatic test_order();
    clear_mem();
    mem[0] = 16'h7A20; mem[1] = 16'h7820; mem[2] = 16'h7260;
    do_reset();
    tick(4);
    check("R7 clr-cmp-inc", ac, 16'h0000);
    tick(4);
    check("R7 clr-inc", ac, 16'h0001);
    tick(4);
    check("R7 cmp-rol-inc ac", ac, 16'hFFFD);
    check("R7 cmp-rol-inc e", e_flag, 1);
  endtask

  task automatic test_halt();
    clear_mem();
    mem[0] = 16'h7021; mem[1] = 16'h7020;
    do_reset();
    tick(4);
    check("R8 halted", halted, 1);
    check("R8 step zero", t_step, 0);
    check("R8 inc same word", ac, 16'h0001);
    tick(10);
    check("R8 frozen ac", ac, 16'h0001);
    check("R8 frozen pc", pc, 1);
    check("R8 still halted", halted, 1);
  endtask

  task automatic test_input();
    clear_mem();
    mem[0] = 16'h2050; mem[8'h50] = 16'h12FF;
    mem[1] = 16'hF800; mem[2] = 16'hF000;
    in_valid = 1'b0;
    do_reset();
    tick(6);
    tick(3);
    check("R9 wait T3", t_step, 7'b0001000);
    check("R9 ready", in_ready, 1);
    tick(5);
    check("R9 stall T3", t_step, 7'b0001000);
    check("R9 stall ac", ac, 16'h12FF);
    in_data = 8'hA5; in_valid = 1'b1;
    tick(1);
    in_valid = 1'b0;
    check("R9 byte in", ac, 16'h12A5);
    check("R9 T0 after", t_step, 7'b0000001);
    check("R9 ready drop", in_ready, 0);
    tick(4);
    check("R9 no-bit io", ac, 16'h12A5);
    check("R9 no-bit pc", pc, 3);
    check("R9 no-bit T0", t_step, 7'b0000001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(1);
    test_reset();
    test_fetch();
    test_memref();
    test_indirect();
    test_regref();
    test_order();
    test_halt();
    test_input();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule